// File: doc/BRIEF.md
# Synchronous master serial receiver

This block is the receive side of a clock-master synchronous serial port. It generates the shift clock from a programmable divisor and samples a single data line on each falling edge of that clock. Bits arrive least significant bit first, and the block builds 8-bit words, or 9-bit words when the ninth bit is enabled. Finished words go into a holding register. A receive-complete flag shows that a word is waiting, and it can also drive an interrupt line.

Software controls the block through a write strobe on a control register, a write strobe on a divisor register and a read strobe on the holding register. A word can be requested one at a time through a single-shot enable that clears itself, or words can run back to back through a continuous enable. When both enables are set, the continuous enable wins. If a word completes while the previous one is still unread, the block raises an overrun flag and stops. Software clears that flag by writing the control register with the continuous enable at zero.

Top module: `smrx_top`

## Requirements
- R1: After reset, sck is 0, rx_done, rx_ovr and irq are 0, rx_data and rx_bit9 are 0, and ctl_rdata reads 0.
- R2: Reception runs only while control bits port_en [0], sync_sel [1] and master_sel [2] are all 1 and either single_en [4] or cont_en [5] is 1. Otherwise sck holds its idle level and no word completes.
- R3: One shift clock period lasts 4*(D+1) system clocks, with the high and low halves equal. D is the whole 16-bit divisor when wide_div [7] is 1, and only its low byte when wide_div is 0.
- R4: The data line is sampled on each falling edge of the unflipped shift clock. The first sampled bit lands in rx_data[0] and the eighth in rx_data[7].
- R5: With word9 [3] set, each word has nine bits and the ninth sampled bit appears on rx_bit9. With word9 clear, rx_bit9 reads 0.
- R6: With only single_en set, exactly one word is received. single_en then reads back as 0 and sck stays at its idle level.
- R7: With cont_en set, words follow each other without a gap until cont_en is cleared.
- R8: With both enables set, reception continues after the first word and single_en stays at 1.
- R9: rx_done rises in the same cycle that the last bit of a word is sampled. A data_rd strobe clears it. irq equals rx_done while irq_en [8] is 1 and is 0 otherwise.
- R10: A word that completes while rx_done is still 1 sets rx_ovr. That word is discarded, rx_data keeps the older word, and no further shift clock edges occur.
- R11: rx_ovr clears only on a control write with cont_en at 0. A write with cont_en at 1 leaves it set.
- R12: With idle_high [6] set, sck idles at 1 and its waveform is inverted. Sampling still happens as sck goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control register write value (bit fields as in the requirements) |
| div_wr | input | 1 | Divisor register write strobe |
| div_wdata | input | 16 | Divisor write value |
| data_rd | input | 1 | Holding register read strobe; clears rx_done |
| sdi | input | 1 | Serial data line |
| sck | output | 1 | Generated shift clock |
| rx_data | output | 8 | Holding register |
| rx_bit9 | output | 1 | Ninth bit of the held word |
| rx_done | output | 1 | Receive-complete flag |
| rx_ovr | output | 1 | Overrun error flag |
| irq | output | 1 | Receive interrupt |
| ctl_rdata | output | 9 | Control register read-back |

## Verification
After a control write, the first rising shift clock edge is due 2*(D+1) system clocks after the write edge. Each falling edge follows one half-period later. rx_done, rx_data and rx_bit9 update on the very system edge where the last falling shift edge occurs, so they are valid half a system cycle later. A data_rd strobe takes effect on the next edge. The bench watches sck at every falling system-clock edge, counts falling shift edges, and records the length of each period and of its high half. It drives sdi and strobes, and reads results, one time unit after a falling edge, away from the sampling edge. Because every check waits on a counted shift edge or a strobe edge, no check depends on a fixed delay guessed from the divisor.

// File: rtl/smrx_pkg.sv
package smrx_pkg;

    typedef struct packed {
        logic irq_en;
        logic wide_div;
        logic idle_high;
        logic cont_en;
        logic single_en;
        logic word9;
        logic master_sel;
        logic sync_sel;
        logic port_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/smrx_clkgen.sv
module smrx_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_eff,
    output logic             lvl,
    output logic             fall_now
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t q, d;
    logic [CW-1:0] lim;
    logic          tc;

    always_comb begin
        lim = {div_eff, 1'b1};
        tc  = (q.cnt == lim);
        d   = q;
        if (!run) begin
            d = '0;
        end else if (tc) begin
            d.cnt = '0;
            d.lvl = ~q.lvl;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl      = q.lvl;
    assign fall_now = run & q.lvl & tc;

    // R2
    stop_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !q.lvl);

    // R3
    edge_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.cnt != lim) |=> $stable(q.lvl));

endmodule

// File: rtl/smrx_shift.sv
module smrx_shift #(
    parameter int DATA_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fall_now,
    input  logic          sdi,
    input  logic          word9,
    output logic          word_end,
    output logic [DATA_W:0] word_out
);
    localparam int SW = DATA_W + 1;
    localparam int BW = $clog2(SW + 1);

    typedef struct packed {
        logic [SW-1:0] sr;
        logic [BW-1:0] cnt;
    } st_t;

    st_t q, d;
    logic [SW-1:0] nxt_sr;
    logic [BW-1:0] last;

    always_comb begin
        last     = word9 ? BW'(SW - 1) : BW'(DATA_W - 1);
        nxt_sr   = {sdi, q.sr[SW-1:1]};
        word_end = fall_now && (q.cnt == last);
        word_out = word9 ? nxt_sr : {1'b0, nxt_sr[SW-1:1]};
        d = q;
        if (!run) begin
            d.cnt = '0;
        end else if (fall_now) begin
            d.sr  = nxt_sr;
            d.cnt = word_end ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= BW'(DATA_W));

    // R4
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_now |=> $stable(q.sr));

endmodule

// File: rtl/smrx_regs.sv
module smrx_regs
    import smrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  ctl_t              ctl_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              data_rd,
    input  logic              word_end,
    input  logic [DATA_W:0]   word_in,
    output logic              run,
    output logic [DIV_W-1:0]  div_eff,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              done,
    output logic              ovr,
    output logic              irq
);
    localparam int NW = DIV_W / 2;

    typedef struct packed {
        ctl_t              ctl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] data;
        logic              b9;
        logic              done;
        logic              ovr;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (ctl_wr) d.ctl = ctl_wdata;
        if (word_end && !q.ctl.cont_en && !ctl_wr) d.ctl.single_en = 1'b0;
        if (div_wr) d.div = div_wdata;
        if (data_rd) d.done = 1'b0;
        if (word_end) begin
            if (q.done && !data_rd) begin
                d.ovr = 1'b1;
            end else begin
                d.data = word_in[DATA_W-1:0];
                d.b9   = word_in[DATA_W];
                d.done = 1'b1;
            end
        end
        if (ctl_wr && !ctl_wdata.cont_en) d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run = q.ctl.port_en & q.ctl.sync_sel & q.ctl.master_sel
               & (q.ctl.single_en | q.ctl.cont_en) & ~q.ovr;
    assign div_eff = q.ctl.wide_div ? q.div : DIV_W'(q.div[NW-1:0]);
    assign ctl     = q.ctl;
    assign rx_data = q.data;
    assign rx_bit9 = q.b9;
    assign done    = q.done;
    assign ovr     = q.ovr;
    assign irq     = q.done & q.ctl.irq_en;

    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(word_end));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !word_end) |=> !q.done);

    // R10
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> $stable(q.data));

    // R6
    single_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !q.ctl.cont_en && !ctl_wr) |=> !q.ctl.single_en);

endmodule

// File: rtl/smrx_top.sv
module smrx_top
    import smrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              data_rd,
    input  logic              sdi,
    output logic              sck,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              rx_ovr,
    output logic              irq,
    output logic [CTL_W-1:0]  ctl_rdata
);
    logic             run, lvl, fall_now, word_end;
    logic [DIV_W-1:0] div_eff;
    logic [DATA_W:0]  word;
    ctl_t             ctl;

    smrx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_t'(ctl_wdata)),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .data_rd(data_rd), .word_end(word_end), .word_in(word),
        .run(run), .div_eff(div_eff), .ctl(ctl),
        .rx_data(rx_data), .rx_bit9(rx_bit9),
        .done(rx_done), .ovr(rx_ovr), .irq(irq)
    );

    smrx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .div_eff(div_eff),
        .lvl(lvl), .fall_now(fall_now)
    );

    smrx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .fall_now(fall_now),
        .sdi(sdi), .word9(ctl.word9),
        .word_end(word_end), .word_out(word)
    );

    assign sck       = lvl ^ ctl.idle_high;
    assign ctl_rdata = CTL_W'(ctl);

    // R10
    ovr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> !lvl);

endmodule

// File: tb/sim_smrx_top.sv
module sim_smrx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic       div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic       data_rd = 1'b0;
    logic       sdi = 1'b0;
    logic       sck, rx_bit9, rx_done, rx_ovr, irq;
    logic [7:0] rx_data;
    logic [8:0] ctl_rdata;

    int total = 0;
    int bad = 0;
    int fall_cnt = 0;
    int per_ctr = 0;
    int hi_ctr = 0;
    int last_per = 0;
    int last_hi = 0;
    logic prev_act = 1'b0;

    always #4 clk = ~clk;

    smrx_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .data_rd(data_rd), .sdi(sdi),
        .sck(sck), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done),
        .rx_ovr(rx_ovr), .irq(irq), .ctl_rdata(ctl_rdata)
    );

    // {word9, idle_high, wide_div, divisor[15:0], data[8:0]}
    localparam logic [27:0] VEC [0:3] = '{
        {1'b0, 1'b0, 1'b0, 16'h0000, 9'h0A5},
        {1'b1, 1'b0, 1'b0, 16'h0103, 9'h1C3},
        {1'b0, 1'b1, 1'b1, 16'h0100, 9'h03C},
        {1'b1, 1'b1, 1'b0, 16'h0005, 9'h17E}
    };

    // falling-edge monitor of the unflipped shift clock
    always @(negedge clk) begin
        logic act;
        act = sck ^ ctl_rdata[6];
        if (prev_act && !act) begin
            fall_cnt <= fall_cnt + 1;
            last_per <= per_ctr + 1;
            last_hi  <= hi_ctr;
            per_ctr  <= 0;
            hi_ctr   <= 0;
        end else begin
            per_ctr <= per_ctr + 1;
            if (act) hi_ctr <= hi_ctr + 1;
        end
        prev_act <= act;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mkctl(input logic single, input logic cont,
                                         input logic w9, input logic ih,
                                         input logic wide, input logic ie);
        return {ie, wide, ih, cont, single, w9, 1'b1, 1'b1, 1'b1};
    endfunction

    task automatic write_ctl(input logic [8:0] v);
        ctl_wdata = v;
        ctl_wr = 1'b1;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic write_div(input logic [15:0] v);
        div_wdata = v;
        div_wr = 1'b1;
        tick();
        div_wr = 1'b0;
    endtask

    task automatic read_data();
        data_rd = 1'b1;
        tick();
        data_rd = 1'b0;
    endtask

    task automatic wait_fall(input string req);
        int start;
        int n;
        start = fall_cnt;
        n = 0;
        while (fall_cnt == start && n < 5000) begin
            tick();
            n++;
        end
        if (fall_cnt == start) chk(1'b0, {req, " shift edge timeout"}, 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] stream;
        int f0;
        tick();
        tick();
        // R1 reset state
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(rx_done == 1'b0, "R1 rx_done", rx_done, 0);
        chk(rx_ovr == 1'b0, "R1 rx_ovr", rx_ovr, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(rx_data == 8'h00 && rx_bit9 == 1'b0, "R1 rx_data", rx_data, 0);
        chk(ctl_rdata == 9'h000, "R1 ctl_rdata", ctl_rdata, 0);
        rst_n = 1'b1;
        tick();

        // vector table walk: single-word reception
        for (int k = 0; k < 4; k++) begin
            logic w9, ih, wide;
            logic [15:0] dv;
            logic [8:0] dat;
            int eff, per, nb;
            w9 = VEC[k][27]; ih = VEC[k][26]; wide = VEC[k][25];
            dv = VEC[k][24:9]; dat = VEC[k][8:0];
            eff = wide ? int'(dv) : int'(dv[7:0]);
            per = 4 * (eff + 1);
            nb = w9 ? 9 : 8;
            write_div(dv);
            sdi = dat[0];
            write_ctl(mkctl(1'b1, 1'b0, w9, ih, wide, 1'b0));
            for (int i = 0; i < nb; i++) begin
                wait_fall("R4");
                if (i + 1 < nb) sdi = dat[i+1];
                if (i == 2) begin
                    chk(last_per == per, "R3 period", last_per, per);
                    chk(last_hi == per / 2, "R3 high half", last_hi, per / 2);
                end
            end
            chk(rx_done == 1'b1, "R9 done set", rx_done, 1);
            chk(rx_data == dat[7:0], "R4 data", rx_data, dat[7:0]);
            chk(rx_bit9 == (w9 & dat[8]), "R5 ninth bit", rx_bit9, w9 & dat[8]);
            chk(irq == 1'b0, "R9 irq masked", irq, 0);
            chk(ctl_rdata[4] == 1'b0, "R6 single self-clear", ctl_rdata[4], 0);
            f0 = fall_cnt;
            repeat (2 * per + 10) tick();
            chk(fall_cnt == f0, "R6 no further edges", fall_cnt - f0, 0);
            chk(sck == ih, "R12 idle level", sck, ih);
            read_data();
            chk(rx_done == 1'b0, "R9 read clears", rx_done, 0);
            write_ctl(9'h000);
        end

        // R2 gating: master select missing
        write_div(16'h0000);
        write_ctl(9'h013);
        f0 = fall_cnt;
        repeat (40) tick();
        chk(fall_cnt == f0 && sck == 1'b0, "R2 no clock", fall_cnt - f0, 0);
        chk(rx_done == 1'b0, "R2 no word", rx_done, 0);
        chk(ctl_rdata[4] == 1'b1, "R2 single kept", ctl_rdata[4], 1);
        write_ctl(9'h000);

        // R7 continuous with interrupt enabled
        stream = {8'h3D, 8'h96};
        sdi = stream[0];
        write_ctl(mkctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 16; i++) begin
            wait_fall("R7");
            if (i < 15) sdi = stream[i+1];
            if (i == 7) begin
                chk(rx_done && rx_data == 8'h96, "R7 first word", rx_data, 8'h96);
                chk(irq == 1'b1, "R9 irq raised", irq, 1);
                read_data();
                chk(irq == 1'b0 && rx_done == 1'b0, "R9 irq cleared", irq, 0);
            end
        end
        chk(rx_done && rx_data == 8'h3D, "R7 second word", rx_data, 8'h3D);
        chk(rx_ovr == 1'b0, "R10 no overrun when read", rx_ovr, 0);
        read_data();
        wait_fall("R7 still running");
        write_ctl(mkctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        f0 = fall_cnt;
        repeat (20) tick();
        chk(fall_cnt == f0, "R7 stops when cleared", fall_cnt - f0, 0);
        write_ctl(9'h000);

        // R10 / R11 overrun
        stream = {8'hC4, 8'h5B};
        sdi = stream[0];
        write_ctl(mkctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 16; i++) begin
            wait_fall("R10");
            if (i < 15) sdi = stream[i+1];
        end
        chk(rx_ovr == 1'b1, "R10 overrun set", rx_ovr, 1);
        chk(rx_data == 8'h5B, "R10 older word kept", rx_data, 8'h5B);
        f0 = fall_cnt;
        repeat (30) tick();
        chk(fall_cnt == f0 && sck == 1'b0, "R10 halted", fall_cnt - f0, 0);
        write_ctl(mkctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        chk(rx_ovr == 1'b1, "R11 kept with cont set", rx_ovr, 1);
        write_ctl(mkctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk(rx_ovr == 1'b0, "R11 cleared", rx_ovr, 0);
        chk(rx_done == 1'b1 && rx_data == 8'h5B, "R10 done retained", rx_data, 8'h5B);
        read_data();
        write_ctl(9'h000);

        // R8 precedence: both enables set
        stream = {8'h00, 8'hE1};
        sdi = stream[0];
        write_ctl(mkctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 8; i++) begin
            wait_fall("R8");
            sdi = stream[i+1];
        end
        chk(rx_done && rx_data == 8'hE1, "R8 word", rx_data, 8'hE1);
        read_data();
        wait_fall("R8 continues");
        chk(ctl_rdata[4] == 1'b1, "R8 single kept", ctl_rdata[4], 1);
        write_ctl(9'h000);
        f0 = fall_cnt;
        repeat (20) tick();
        chk(fall_cnt == f0, "R2 stop after clear", fall_cnt - f0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule